// File: doc/BRIEF.md
# Slot-Timed Priority Bus Access Cluster

This block arbitrates a single shared broadcast medium among a small group of nodes without a central arbiter. Every node owns a fixed slot number: node index i (counting from 0) has slot number i+1. While the medium is quiet, every node counts the idle cycles. A node that has a message pending may start sending only in the idle cycle whose count equals its slot number. Any activity on the medium restarts every count, so two nodes can never reach their slots together. A lower slot number therefore gets earlier access.

Each node runs a four-state controller with these states: busy (the medium is in use or the node has not yet decided), skip (no message this round), waiting (message pending) and sending. The medium-active signal is the OR of all sending flags. A node decides between skip and waiting only on the first idle cycle after the medium goes quiet. This is the start of a round. The cycle right after reset also counts as a round start. A sending node keeps the medium until its end-of-message strobe arrives. The frame contents, bit timing and physical signalling are handled elsewhere.

Top module: `slot_bus_cluster`

## Requirements
- R1: While reset is high, all sending, waiting and skipping flags are 0 and bus_active is 0. The first cycle after reset is released is a round start.
- R2: Every idle count returns to 0 after any cycle in which bus_active is 1. A waiting node with slot number q therefore starts sending q+1 cycles after the round-start cycle.
- R3: Each idle count rises by one per idle cycle and saturates at SLOT_LIMIT. Node 3 (slot 4), waiting alone, raises its sending flag 5 cycles after the round start and not before.
- R4: In a round-start cycle, a busy node moves to waiting if its want_send bit is 1 and to skip otherwise. The new flag is visible in the next cycle.
- R5: A busy node ignores want_send outside a round-start cycle. A node in skip also ignores want_send.
- R6: A skipping node returns to busy (skipping flag clears) in the cycle after the first cycle with bus_active at 1.
- R7: A waiting node stays waiting while bus_active is 1. It raises its sending flag in the cycle after the idle cycle in which the count equals its slot number.
- R8: A sending node keeps sending while msg_end is 0. It returns to busy in the cycle after msg_end is 1. In any other state, msg_end has no effect.
- R9: At most one sending flag is 1 in any cycle, and bus_active equals the OR of the sending flags.
- R10: When several nodes wait, the lowest index sends first. After it releases the medium, the next waiting node sends in the new round at its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| want_send | input | NODES | Per-node message-pending request, sampled at round start |
| msg_end | input | NODES | Per-node end-of-message strobe while sending |
| sending | output | NODES | Per-node sending flag (registered) |
| waiting | output | NODES | Per-node waiting flag (registered) |
| skipping | output | NODES | Per-node skipping flag (registered) |
| bus_active | output | 1 | OR of all sending flags |

## Verification
The bench builds the cluster with its defaults: four nodes and a count limit of 99. With these values every slot is reached within five cycles of a round start, so the exact grant cycle of each node can be checked. The bench also covers priority among all four nodes waiting together, requests that arrive while a node is busy, and an end strobe sent to a node that is not sending. A long all-skip stretch of more than a hundred idle cycles drives every count to its saturation value. The bench then confirms that the flags stay frozen.

// File: rtl/slotbus_pkg.sv
package slotbus_pkg;
  typedef enum logic [1:0] {
    ND_BUSY = 2'd0,
    ND_SKIP = 2'd1,
    ND_WAIT = 2'd2,
    ND_SEND = 2'd3
  } node_state_e;
endpackage

// File: rtl/round_start_det.sv
// Marks the first quiet cycle after the medium was in use.
// The cycle after reset also counts as a round start.
module round_start_det (
  input  logic clk,
  input  logic rst,
  input  logic bus_active,
  output logic round_start
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b1;
    else     active_q <= bus_active;
  end

  assign round_start = active_q && !bus_active;

  a_r1_start_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> round_start);
endmodule

// File: rtl/slot_counter.sv
// Counts idle cycles, restarts on activity, saturates at the limit.
module slot_counter #(
  parameter int LIMIT = 99,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_active,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || bus_active) count <= '0;
    else if (count < TOP)  count <= count + 1'b1;
  end

  a_r2_clear_on_activity: assert property (@(posedge clk) disable iff (rst)
    bus_active |=> count == '0);
  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (!bus_active && count < TOP) |=> count == CW'($past(count) + 1'b1));
  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    (!bus_active && count == TOP) |=> count == TOP);
endmodule

// File: rtl/node_ctrl.sv
// Four-state access controller for one node; flags are registered.
module node_ctrl
  import slotbus_pkg::*;
#(
  parameter int PRIO = 1,
  parameter int CW   = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          round_start,
  input  logic          bus_active,
  input  logic          want,
  input  logic          msg_end,
  input  logic [CW-1:0] count,
  output logic          is_send,
  output logic          is_wait,
  output logic          is_skip
);
  localparam logic [CW-1:0] MY_SLOT = CW'(PRIO);

  node_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ND_BUSY: if (round_start) state_d = want ? ND_WAIT : ND_SKIP;
      ND_SKIP: if (bus_active) state_d = ND_BUSY;
      ND_WAIT: if (!bus_active && count == MY_SLOT) state_d = ND_SEND;
      ND_SEND: if (msg_end) state_d = ND_BUSY;
      default: state_d = ND_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ND_BUSY;
      is_send <= 1'b0;
      is_wait <= 1'b0;
      is_skip <= 1'b0;
    end else begin
      state_q <= state_d;
      is_send <= (state_d == ND_SEND);
      is_wait <= (state_d == ND_WAIT);
      is_skip <= (state_d == ND_SKIP);
    end
  end

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ND_BUSY && !round_start) |=> state_q == ND_BUSY);
  a_r6_skip_returns: assert property (@(posedge clk) disable iff (rst)
    (state_q == ND_SKIP && bus_active) |=> state_q == ND_BUSY);
  a_r7_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ND_WAIT && bus_active) |=> state_q == ND_WAIT);
  a_r7_grant_at_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(is_send) |-> $past(count) == MY_SLOT);
  a_r8_send_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ND_SEND && !msg_end) |=> is_send);
  a_r8_send_exits: assert property (@(posedge clk) disable iff (rst)
    (state_q == ND_SEND && msg_end) |=> state_q == ND_BUSY);
endmodule

// File: rtl/slot_bus_cluster.sv
module slot_bus_cluster #(
  parameter int NODES      = 4,
  parameter int SLOT_LIMIT = 99
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] want_send,
  input  logic [NODES-1:0] msg_end,
  output logic [NODES-1:0] sending,
  output logic [NODES-1:0] waiting,
  output logic [NODES-1:0] skipping,
  output logic             bus_active
);
  localparam int CW = $clog2(SLOT_LIMIT + 1);

  logic          round_start;
  logic [CW-1:0] cnt [NODES];

  assign bus_active = |sending;

  round_start_det u_start (
    .clk         (clk),
    .rst         (rst),
    .bus_active  (bus_active),
    .round_start (round_start)
  );

  for (genvar i = 0; i < NODES; i++) begin : g_node
    slot_counter #(.LIMIT(SLOT_LIMIT), .CW(CW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .bus_active (bus_active),
      .count      (cnt[i])
    );

    node_ctrl #(.PRIO(i + 1), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .round_start (round_start),
      .bus_active  (bus_active),
      .want        (want_send[i]),
      .msg_end     (msg_end[i]),
      .count       (cnt[i]),
      .is_send     (sending[i]),
      .is_wait     (waiting[i]),
      .is_skip     (skipping[i])
    );

    a_r9_counts_agree: assert property (@(posedge clk) disable iff (rst)
      cnt[i] == cnt[0]);
  end

  a_r9_single_sender: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sending));
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) |-> (sending == '0 && waiting == '0 && skipping == '0));
endmodule

// File: tb/tb_slot_bus_cluster.sv
module tb_slot_bus_cluster;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] want_send = '0;
  logic [N-1:0] msg_end = '0;
  logic [N-1:0] sending, waiting, skipping;
  logic         bus_active;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  slot_bus_cluster #(.NODES(N), .SLOT_LIMIT(99)) dut (
    .clk(clk), .rst(rst), .want_send(want_send), .msg_end(msg_end),
    .sending(sending), .waiting(waiting), .skipping(skipping),
    .bus_active(bus_active)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Advance one cycle; R9 invariant checked every cycle.
  task automatic step();
    @(posedge clk);
    #1;
    chk("R9", "one sender", 32'($onehot0(sending)), 32'd1);
    chk("R9", "bus_active is OR", 32'(bus_active), 32'(|sending));
  endtask

  // Leaves the bench in the round-start cycle right after reset (C0).
  task automatic do_reset(input logic [N-1:0] w);
    rst = 1'b1; want_send = w; msg_end = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "flags in reset", 32'({sending, waiting, skipping}), 32'd0);
    chk("R1", "bus idle in reset", 32'(bus_active), 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_single();
    do_reset(4'b0100);
    step();  // C1
    chk("R4", "waiting", 32'(waiting), 32'h4);
    chk("R4", "skipping", 32'(skipping), 32'hb);
    step(); step();  // C3
    chk("R7", "not before slot", 32'(sending), 32'h0);
    step();  // C4
    chk("R7", "send at slot 3", 32'(sending), 32'h4);
    chk("R6", "skip held in first active cycle", 32'(skipping), 32'hb);
    step();  // C5
    chk("R6", "skip cleared", 32'(skipping), 32'h0);
    chk("R8", "holds", 32'(sending), 32'h4);
    step();
    chk("R8", "still holds", 32'(sending), 32'h4);
    msg_end = 4'b0100; want_send = '0;
    step();  // round start
    msg_end = '0;
    chk("R8", "released", 32'(sending), 32'h0);
    step();
    chk("R4", "all skip in new round", 32'(skipping), 32'hf);
  endtask

  task automatic t_prio();
    do_reset(4'b1111);
    step();  // C1
    chk("R4", "all waiting", 32'(waiting), 32'hf);
    step();  // C2
    chk("R10", "lowest index first", 32'(sending), 32'h1);
    chk("R10", "others wait", 32'(waiting), 32'he);
    step();
    chk("R7", "others keep waiting while active", 32'(waiting), 32'he);
    msg_end = 4'b0001; want_send = 4'b1110;
    step();  // T
    msg_end = '0;
    chk("R8", "node0 released", 32'(sending), 32'h0);
    step();  // T+1
    chk("R4", "node0 skips new round", 32'(skipping), 32'h1);
    chk("R7", "waiting carried over", 32'(waiting), 32'he);
    step();  // T+2
    chk("R2", "count restarted, slot 2 not yet", 32'(sending), 32'h0);
    step();  // T+3
    chk("R10", "next node at its slot", 32'(sending), 32'h2);
  endtask

  task automatic t_late();
    do_reset(4'b0001);
    step();  // C1
    chk("R4", "node0 waits", 32'(waiting), 32'h1);
    step();  // C2
    chk("R7", "node0 sends at slot 1", 32'(sending), 32'h1);
    step();  // C3
    chk("R6", "skippers back to busy", 32'(skipping), 32'h0);
    want_send = 4'b0011;
    msg_end = 4'b0100;
    step();  // C4
    chk("R5", "late want ignored", 32'(waiting), 32'h0);
    msg_end = '0;
    chk("R8", "end strobe on busy node ignored", 32'({sending, skipping}), 32'h10);
    step();
    chk("R5", "still busy", 32'(waiting), 32'h0);
    msg_end = 4'b0001; want_send = 4'b0010;
    step();  // T
    msg_end = '0;
    step();  // T+1
    chk("R5", "request taken at round start", 32'(waiting), 32'h2);
    chk("R4", "rest skip", 32'(skipping), 32'hd);
    step(); step();  // T+3
    chk("R7", "node1 sends at slot 2", 32'(sending), 32'h2);
  endtask

  task automatic t_last();
    do_reset(4'b1000);
    repeat (4) step();  // C4
    chk("R3", "slot 4 not reached", 32'(sending), 32'h0);
    step();  // C5
    chk("R3", "slot 4 grant", 32'(sending), 32'h8);
  endtask

  task automatic t_idle();
    do_reset(4'b0000);
    step();
    chk("R4", "all skip", 32'(skipping), 32'hf);
    want_send = 4'b1111;
    repeat (110) step();
    chk("R3", "saturated idle, no sender", 32'(sending), 32'h0);
    chk("R5", "skip ignores want", 32'(skipping), 32'hf);
    chk("R5", "nobody waiting", 32'(waiting), 32'h0);
  endtask

  initial begin
    t_single();
    t_prio();
    t_late();
    t_last();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule